// File: doc/BRIEF.md
# Two-Tag Translation Lookaside Buffer

This block is a small fully associative translation cache for a system that translates addresses in two stages. Every entry remembers a virtual page, the physical page it maps to, an attribute field, the translation regime it was filled for, a virtual machine tag and an address space tag. Because both tags are stored, translations belonging to several guests, and to several applications inside each guest, can be resident together without aliasing.

A lookup presents a virtual page, the current machine tag, the current address space tag and the regime. The hit flag, physical page and attributes follow combinationally from the registered entry array. A fill port installs translations. Round-robin replacement picks the victim, and a fill whose key is already present rewrites that entry instead. Three invalidate operations discard stale translations in a single cycle: everything, by machine tag, or by machine tag plus address space tag. A run-time control bit selects 8-bit or 16-bit machine tags.

Top module: `vtag_tlb`

## Requirements
- R1: After synchronous reset every entry is invalid and a lookup reports a miss, with `pa_o` and `attr_o` at zero.
- R2: A fill becomes visible to lookups from the cycle after the fill edge. A hitting lookup returns the stored page and attributes combinationally. A miss drives zeros.
- R3: A guest entry (regime code 2'b00) hits only when its stored machine tag equals the current one. The same virtual page and address space tag under a different machine tag misses.
- R4: When `vmid16_i` is 0, bits 15:8 of the machine tag are taken as zero for fill, lookup and invalidate. When it is 1, all 16 bits take part.
- R5: Entries filled with regime code 2'b01 (hypervisor), 2'b10 or 2'b11 (monitor) store no machine tag and hit whatever the current machine tag is. The stored regime code must still equal the lookup regime code.
- R6: A non-global entry needs an equal address space tag to hit. A global entry (`fill_global_i`=1) skips that compare, but a guest global entry still needs its machine tag to match.
- R7: The buffer has 8 entries filled in round-robin order from entry 0. The ninth fill of a distinct key evicts the first one.
- R8: A fill whose page, regime, stored machine tag and address space tag equal a valid entry rewrites that entry, including its global bit, and does not advance the round-robin pointer.
- R9: `inv_op_i` encodes 2'b01 clear all, 2'b10 clear guest entries with the given machine tag, and 2'b11 clear non-global guest entries matching both given tags. The effect is visible in the next cycle. Code 2'b00 does nothing.
- R10: When a fill and an invalidate occur in the same cycle, the invalidate is applied to the array after the fill, so the freshly written entry can be cleared.
- R11: When several entries hit, the lowest-numbered one supplies `pa_o` and `attr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vmid16_i | input | 1 | 1 selects 16-bit machine tags, 0 selects 8-bit |
| lk_va_i | input | 20 | Lookup virtual page |
| lk_vmid_i | input | 16 | Current machine tag |
| lk_asid_i | input | 16 | Current address space tag |
| lk_regime_i | input | 2 | Lookup regime code |
| hit_o | output | 1 | Lookup hit |
| pa_o | output | 20 | Physical page of the hit |
| attr_o | output | 8 | Attributes of the hit |
| fill_en_i | input | 1 | Install a translation this cycle |
| fill_va_i | input | 20 | Fill virtual page |
| fill_vmid_i | input | 16 | Fill machine tag |
| fill_asid_i | input | 16 | Fill address space tag |
| fill_regime_i | input | 2 | Fill regime code |
| fill_global_i | input | 1 | Fill global bit |
| fill_pa_i | input | 20 | Fill physical page |
| fill_attr_i | input | 8 | Fill attributes |
| inv_op_i | input | 2 | Invalidate operation |
| inv_vmid_i | input | 16 | Machine tag for invalidate |
| inv_asid_i | input | 16 | Address space tag for invalidate |

## Verification
The assertions assume a fixed entry count of at least two and a reset that is held for at least one edge before use. They also assume that `vmid16_i` stays steady for the cycle in which it is sampled; no further handshake is required, since every input combination is legal. The random stimulus draws pages, tags and regimes from small pools, so repeated keys, in-place rewrites, multiple hits and cross-guest tag collisions all occur often. It flips the tag width only occasionally and mixes invalidates into the same cycles as fills, which keeps every input inside that assumption while reaching the R10 overlap case.

// File: rtl/vtag_tlb_pkg.sv
package vtag_tlb_pkg;
  localparam logic [1:0] REG_GUEST = 2'b00;
  localparam logic [1:0] REG_HYP   = 2'b01;

  localparam logic [1:0] INV_NONE  = 2'b00;
  localparam logic [1:0] INV_ALL   = 2'b01;
  localparam logic [1:0] INV_VM    = 2'b10;
  localparam logic [1:0] INV_VMAS  = 2'b11;
endpackage

// File: rtl/vtag_tlb_match.sv
module vtag_tlb_match
  import vtag_tlb_pkg::*;
#(
  parameter int VA_W   = 20,
  parameter int VMID_W = 16,
  parameter int ASID_W = 16
) (
  input  logic              e_valid,
  input  logic [VA_W-1:0]   e_va,
  input  logic [VMID_W-1:0] e_vmid,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [1:0]        e_reg,
  input  logic              e_glb,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_reg,
  input  logic [VA_W-1:0]   f_va,
  input  logic [VMID_W-1:0] f_vmid,
  input  logic [ASID_W-1:0] f_asid,
  input  logic [1:0]        f_reg,
  input  logic              n_valid,
  input  logic [VMID_W-1:0] n_vmid,
  input  logic [ASID_W-1:0] n_asid,
  input  logic [1:0]        n_reg,
  input  logic              n_glb,
  input  logic [1:0]        inv_op,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic [ASID_W-1:0] inv_asid,
  output logic              lk_hit,
  output logic              f_same,
  output logic              inv_kill
);
  logic vm_ok, as_ok, n_vm_hit;

  // Hypervisor and monitor entries carry no machine tag.
  assign vm_ok  = (e_reg != REG_GUEST) || (e_vmid == lk_vmid);
  assign as_ok  = e_glb || (e_asid == lk_asid);
  assign lk_hit = e_valid && (e_va == lk_va) && (e_reg == lk_reg) && vm_ok && as_ok;

  assign f_same = e_valid && (e_va == f_va) && (e_reg == f_reg) &&
                  (e_vmid == f_vmid) && (e_asid == f_asid);

  assign n_vm_hit = n_valid && (n_reg == REG_GUEST) && (n_vmid == inv_vmid);

  always_comb begin
    case (inv_op)
      INV_ALL:  inv_kill = n_valid;
      INV_VM:   inv_kill = n_vm_hit;
      INV_VMAS: inv_kill = n_vm_hit && !n_glb && (n_asid == inv_asid);
      default:  inv_kill = 1'b0;
    endcase
  end
endmodule

// File: rtl/vtag_tlb_select.sv
module vtag_tlb_select #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  // Lowest index wins.
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vtag_tlb_victim.sv
module vtag_tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fill_en,
  input  logic [ENTRIES-1:0] same,
  output logic [IDX_W-1:0]   widx,
  output logic               in_place
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] same_idx;

  vtag_tlb_select #(.ENTRIES(ENTRIES)) same_sel_i (
    .req (same),
    .any (in_place),
    .idx (same_idx)
  );

  assign widx = in_place ? same_idx : ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (fill_en && !in_place) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  a_r7_ptr_step: assert property (@(posedge clk) disable iff (rst)
    fill_en && !in_place |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    fill_en && in_place |=> $stable(ptr_q));
endmodule

// File: rtl/vtag_tlb.sv
module vtag_tlb
  import vtag_tlb_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int VA_W     = 20,
  parameter int PA_W     = 20,
  parameter int ATTR_W   = 8,
  parameter int VMID_W   = 16,
  parameter int NARROW_W = 8,
  parameter int ASID_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vmid16_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [VMID_W-1:0] lk_vmid_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [1:0]        lk_regime_i,
  output logic              hit_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [ATTR_W-1:0] attr_o,
  input  logic              fill_en_i,
  input  logic [VA_W-1:0]   fill_va_i,
  input  logic [VMID_W-1:0] fill_vmid_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [1:0]        fill_regime_i,
  input  logic              fill_global_i,
  input  logic [PA_W-1:0]   fill_pa_i,
  input  logic [ATTR_W-1:0] fill_attr_i,
  input  logic [1:0]        inv_op_i,
  input  logic [VMID_W-1:0] inv_vmid_i,
  input  logic [ASID_W-1:0] inv_asid_i
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int HIGH_W = VMID_W - NARROW_W;

  logic [ENTRIES-1:0] valid_q;
  logic [VA_W-1:0]    e_va   [ENTRIES];
  logic [PA_W-1:0]    e_pa   [ENTRIES];
  logic [ATTR_W-1:0]  e_attr [ENTRIES];
  logic [VMID_W-1:0]  e_vmid [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [1:0]         e_reg  [ENTRIES];
  logic [ENTRIES-1:0] e_glb;

  logic [VMID_W-1:0] lk_vm, f_vm_eff, f_vm, inv_vm;
  logic [ENTRIES-1:0] hit_vec, same_vec, kill_vec, wr_vec;
  logic [IDX_W-1:0]   hit_idx, widx;
  logic               in_place;

  // Narrow mode clears the upper tag bits everywhere a tag enters.
  assign lk_vm    = vmid16_i ? lk_vmid_i   : {{HIGH_W{1'b0}}, lk_vmid_i[NARROW_W-1:0]};
  assign f_vm_eff = vmid16_i ? fill_vmid_i : {{HIGH_W{1'b0}}, fill_vmid_i[NARROW_W-1:0]};
  assign inv_vm   = vmid16_i ? inv_vmid_i  : {{HIGH_W{1'b0}}, inv_vmid_i[NARROW_W-1:0]};
  assign f_vm     = (fill_regime_i == REG_GUEST) ? f_vm_eff : '0;

  vtag_tlb_victim #(.ENTRIES(ENTRIES)) victim_i (
    .clk      (clk),
    .rst      (rst),
    .fill_en  (fill_en_i),
    .same     (same_vec),
    .widx     (widx),
    .in_place (in_place)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              n_valid, n_glb;
    logic [VMID_W-1:0] n_vmid;
    logic [ASID_W-1:0] n_asid;
    logic [1:0]        n_reg;

    assign wr_vec[g] = fill_en_i && (widx == IDX_W'(g));
    // Post-fill view of the entry, seen by the invalidate compare.
    assign n_valid = wr_vec[g] ? 1'b1          : valid_q[g];
    assign n_glb   = wr_vec[g] ? fill_global_i : e_glb[g];
    assign n_vmid  = wr_vec[g] ? f_vm          : e_vmid[g];
    assign n_asid  = wr_vec[g] ? fill_asid_i   : e_asid[g];
    assign n_reg   = wr_vec[g] ? fill_regime_i : e_reg[g];

    vtag_tlb_match #(.VA_W(VA_W), .VMID_W(VMID_W), .ASID_W(ASID_W)) match_i (
      .e_valid  (valid_q[g]),
      .e_va     (e_va[g]),
      .e_vmid   (e_vmid[g]),
      .e_asid   (e_asid[g]),
      .e_reg    (e_reg[g]),
      .e_glb    (e_glb[g]),
      .lk_va    (lk_va_i),
      .lk_vmid  (lk_vm),
      .lk_asid  (lk_asid_i),
      .lk_reg   (lk_regime_i),
      .f_va     (fill_va_i),
      .f_vmid   (f_vm),
      .f_asid   (fill_asid_i),
      .f_reg    (fill_regime_i),
      .n_valid  (n_valid),
      .n_vmid   (n_vmid),
      .n_asid   (n_asid),
      .n_reg    (n_reg),
      .n_glb    (n_glb),
      .inv_op   (inv_op_i),
      .inv_vmid (inv_vm),
      .inv_asid (inv_asid_i),
      .lk_hit   (hit_vec[g]),
      .f_same   (same_vec[g]),
      .inv_kill (kill_vec[g])
    );

    // Payload has no reset so it can map onto distributed RAM.
    always_ff @(posedge clk) begin
      if (wr_vec[g]) begin
        e_va[g]   <= fill_va_i;
        e_pa[g]   <= fill_pa_i;
        e_attr[g] <= fill_attr_i;
        e_vmid[g] <= f_vm;
        e_asid[g] <= fill_asid_i;
        e_reg[g]  <= fill_regime_i;
        e_glb[g]  <= fill_global_i;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) valid_q[g] <= 1'b0;
      else     valid_q[g] <= n_valid && !kill_vec[g];
    end
  end

  vtag_tlb_select #(.ENTRIES(ENTRIES)) hit_sel_i (
    .req (hit_vec),
    .any (hit_o),
    .idx (hit_idx)
  );

  assign pa_o   = hit_o ? e_pa[hit_idx]   : '0;
  assign attr_o = hit_o ? e_attr[hit_idx] : '0;

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> valid_q == '0);

  a_r2_fill_lands: assert property (@(posedge clk) disable iff (rst)
    fill_en_i && inv_op_i == INV_NONE |=> valid_q[$past(widx)]);

  a_r3_guest_tag: assert property (@(posedge clk) disable iff (rst)
    hit_o && lk_regime_i == REG_GUEST |-> e_vmid[hit_idx] == lk_vm);

  a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
    inv_op_i == INV_ALL |=> valid_q == '0);
endmodule

// File: tb/vtag_tlb_tb_top.sv
`timescale 1ns/1ps
module vtag_tlb_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vmid16_i = 1'b1;
  logic [19:0] lk_va_i = '0;
  logic [15:0] lk_vmid_i = '0, lk_asid_i = '0;
  logic [1:0]  lk_regime_i = '0;
  logic        hit_o;
  logic [19:0] pa_o;
  logic [7:0]  attr_o;
  logic        fill_en_i = 1'b0, fill_global_i = 1'b0;
  logic [19:0] fill_va_i = '0, fill_pa_i = '0;
  logic [15:0] fill_vmid_i = '0, fill_asid_i = '0;
  logic [1:0]  fill_regime_i = '0;
  logic [7:0]  fill_attr_i = '0;
  logic [1:0]  inv_op_i = '0;
  logic [15:0] inv_vmid_i = '0, inv_asid_i = '0;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vtag_tlb dut_i (.*);

  // Reference model
  bit          m_v [N];
  logic [19:0] m_va [N], m_pa [N];
  logic [7:0]  m_at [N];
  logic [15:0] m_vm [N], m_as [N];
  logic [1:0]  m_rg [N];
  bit          m_g [N];
  int          m_ptr;

  function automatic logic [15:0] effv(input logic w, input logic [15:0] v);
    return w ? v : {8'h00, v[7:0]};
  endfunction

  function automatic int model_hit();
    logic [15:0] cv = effv(vmid16_i, lk_vmid_i);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_va[i] == lk_va_i && m_rg[i] == lk_regime_i &&
          (m_rg[i] != 2'b00 || m_vm[i] == cv) && (m_g[i] || m_as[i] == lk_asid_i))
        return i;
    return -1;
  endfunction

  task automatic model_step();
    if (fill_en_i) begin
      logic [15:0] fv = (fill_regime_i == 2'b00) ? effv(vmid16_i, fill_vmid_i) : 16'h0;
      int w = -1;
      for (int i = 0; i < N; i++)
        if (w < 0 && m_v[i] && m_va[i] == fill_va_i && m_rg[i] == fill_regime_i &&
            m_vm[i] == fv && m_as[i] == fill_asid_i) w = i;
      if (w < 0) begin w = m_ptr; m_ptr = (m_ptr + 1) % N; end
      m_v[w] = 1; m_va[w] = fill_va_i; m_pa[w] = fill_pa_i; m_at[w] = fill_attr_i;
      m_vm[w] = fv; m_as[w] = fill_asid_i; m_rg[w] = fill_regime_i; m_g[w] = fill_global_i;
    end
    for (int i = 0; i < N; i++) begin
      bit vmh = m_v[i] && m_rg[i] == 2'b00 && m_vm[i] == effv(vmid16_i, inv_vmid_i);
      case (inv_op_i)
        2'b01: m_v[i] = 0;
        2'b10: if (vmh) m_v[i] = 0;
        2'b11: if (vmh && !m_g[i] && m_as[i] == inv_asid_i) m_v[i] = 0;
        default: ;
      endcase
    end
  endtask

  // Compare the combinational lookup against the model.
  task automatic cmp(input string tag);
    int k = model_hit();
    logic [19:0] epa = (k >= 0) ? m_pa[k] : '0;
    logic [7:0]  eat = (k >= 0) ? m_at[k] : '0;
    checks++;
    if (hit_o !== (k >= 0) || pa_o !== epa || attr_o !== eat) begin
      errors++;
      $display("FAIL %s: hit=%0b pa=%h attr=%h expected hit=%0b pa=%h attr=%h",
               tag, hit_o, pa_o, attr_o, k >= 0, epa, eat);
    end
  endtask

  task automatic expect_hit(input string tag, input bit eh, input logic [19:0] epa);
    checks++;
    if (hit_o !== eh || (eh && pa_o !== epa)) begin
      errors++;
      $display("FAIL %s: hit=%0b pa=%h expected hit=%0b pa=%h", tag, hit_o, pa_o, eh, epa);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    fill_en_i = 0; inv_op_i = 2'b00;
    #0.5;
  endtask

  task automatic look(input logic [19:0] va, input logic [15:0] vm, input logic [15:0] as,
                      input logic [1:0] rg);
    lk_va_i = va; lk_vmid_i = vm; lk_asid_i = as; lk_regime_i = rg;
    #0.5;
  endtask

  task automatic fill(input logic [19:0] va, input logic [15:0] vm, input logic [15:0] as,
                      input logic [1:0] rg, input bit g, input logic [19:0] pa);
    fill_en_i = 1; fill_va_i = va; fill_vmid_i = vm; fill_asid_i = as;
    fill_regime_i = rg; fill_global_i = g; fill_pa_i = pa; fill_attr_i = pa[7:0] ^ 8'h5A;
  endtask

  task automatic inv(input logic [1:0] op, input logic [15:0] vm, input logic [15:0] as);
    inv_op_i = op; inv_vmid_i = vm; inv_asid_i = as;
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_ptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #0.5;
    look(20'h5, 16'h3, 16'h1, 2'b00);
    expect_hit("R1 reset miss", 0, 0); cmp("R1");

    fill(20'h5, 16'h3, 16'h1, 2'b00, 0, 20'hAA); tick();
    look(20'h5, 16'h3, 16'h1, 2'b00); expect_hit("R2 fill visible", 1, 20'hAA); cmp("R2");
    look(20'h5, 16'h4, 16'h1, 2'b00); expect_hit("R3 other guest same asid", 0, 0); cmp("R3");

    vmid16_i = 0; fill(20'h6, 16'h1203, 16'h1, 2'b00, 0, 20'hB1); tick();
    look(20'h6, 16'h7703, 16'h1, 2'b00); expect_hit("R4 narrow compare", 1, 20'hB1);
    vmid16_i = 1;
    look(20'h6, 16'h0003, 16'h1, 2'b00); expect_hit("R4 stored upper zero", 1, 20'hB1);
    look(20'h6, 16'h1203, 16'h1, 2'b00); expect_hit("R4 wide compare", 0, 0); cmp("R4");

    fill(20'h9, 16'h55, 16'h2, 2'b01, 0, 20'hC1); tick();
    look(20'h9, 16'h99, 16'h2, 2'b01); expect_hit("R5 hyp ignores vmid", 1, 20'hC1);
    look(20'h9, 16'h99, 16'h2, 2'b00); expect_hit("R5 regime must match", 0, 0); cmp("R5");

    fill(20'hA, 16'h3, 16'h2, 2'b00, 1, 20'hD1); tick();
    look(20'hA, 16'h3, 16'h7, 2'b00); expect_hit("R6 global skips asid", 1, 20'hD1);
    look(20'hA, 16'h4, 16'h7, 2'b00); expect_hit("R6 global keeps vmid", 0, 0);
    look(20'h5, 16'h3, 16'h9, 2'b00); expect_hit("R6 nonglobal asid", 0, 0); cmp("R6");

    fill(20'h5, 16'h3, 16'h1, 2'b00, 0, 20'hBB); tick();
    look(20'h5, 16'h3, 16'h1, 2'b00); expect_hit("R8 in place", 1, 20'hBB); cmp("R8");

    // Two hits: global asid 2 at lower index than non-global asid 5.
    fill(20'hA, 16'h3, 16'h5, 2'b00, 0, 20'hE1); tick();
    look(20'hA, 16'h3, 16'h5, 2'b00); expect_hit("R11 lowest index", 1, 20'hD1); cmp("R11");

    inv(2'b11, 16'h3, 16'h1); tick();
    look(20'h5, 16'h3, 16'h1, 2'b00); expect_hit("R9 vmid+asid", 0, 0);
    look(20'hA, 16'h3, 16'h9, 2'b00); expect_hit("R9 keeps global", 1, 20'hD1);
    inv(2'b10, 16'h3, 16'h0); tick();
    look(20'hA, 16'h3, 16'h9, 2'b00); expect_hit("R9 by vmid", 0, 0);
    look(20'h9, 16'h3, 16'h2, 2'b01); expect_hit("R9 hyp untouched", 1, 20'hC1);
    inv(2'b01, 16'h0, 16'h0); tick();
    look(20'h9, 16'h3, 16'h2, 2'b01); expect_hit("R9 clear all", 0, 0); cmp("R9");

    fill(20'h7, 16'h3, 16'h1, 2'b00, 0, 20'hF1); inv(2'b01, 0, 0); tick();
    look(20'h7, 16'h3, 16'h1, 2'b00); expect_hit("R10 inval after fill", 0, 0); cmp("R10");

    for (int i = 0; i < 9; i++) begin
      fill(20'h100 + 20'(i), 16'h3, 16'h1, 2'b00, 0, 20'h200 + 20'(i)); tick();
    end
    look(20'h100, 16'h3, 16'h1, 2'b00); expect_hit("R7 oldest evicted", 0, 0);
    look(20'h101, 16'h3, 16'h1, 2'b00); expect_hit("R7 second kept", 1, 20'h201);
    look(20'h108, 16'h3, 16'h1, 2'b00); expect_hit("R7 ninth present", 1, 20'h208); cmp("R7");

    void'($urandom(32'd4711));
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 49) == 0) vmid16_i = ~vmid16_i;
      if ($urandom_range(0, 2) == 0)
        fill(20'($urandom_range(0, 7)), ($urandom_range(0, 1) ? 16'h0103 : 16'($urandom_range(3, 5))),
             16'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), $urandom_range(0, 3) == 0,
             20'($urandom));
      if ($urandom_range(0, 11) == 0)
        inv(2'($urandom_range(1, 3)), 16'($urandom_range(3, 5)), 16'($urandom_range(0, 3)));
      look(20'($urandom_range(0, 7)), ($urandom_range(0, 1) ? 16'h0103 : 16'($urandom_range(3, 5))),
           16'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
      cmp("R2/R3/R4/R5/R6/R7/R8/R9/R10/R11 random");
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule